// File: doc/BRIEF.md
# ADC Power-Up Sequencing Controller

This block drives the three power-control lines of an analog-to-digital converter (band-gap enable, reference enable and converter-core enable) and a clock-enable line for the converter. It puts those lines in a safe order and counts the settling time between them in system clock cycles. A separate power-down request pulls the converter back to its lowest state in one cycle. Conversion requests from the rest of the chip pass through this block. A request reaches the conversion engine only once every settling delay has run out.

Two bring-up modes exist. In staged mode the band-gap and reference come up first. The core follows after a long settling delay, and a short core-settling delay comes before ready. In simultaneous mode all three enables rise together and one long settling delay runs before ready. A two-bit power-state output tells which of four operating modes the enables currently put the converter in.

Top module: `adc_pwr_seq`

## Requirements
- R1: After a synchronous active-high reset, clk_en, bg_en, ref_en, core_en, ready and conv_start are low and pwr_state is 0.
- R2: pwr_state encodes 0 = off (clock gated, all off), 1 = low-power (clock on, all off), 2 = standby (clock, band-gap and reference on, core off), 3 = operational (band-gap, reference and core on). While idle, clk_en follows keep_clk with one cycle of delay.
- R3: A power-up request accepted in staged mode (staged_mode = 1) raises clk_en, bg_en and ref_en on the next cycle and leaves core_en low (pwr_state 2).
- R4: In staged mode core_en rises exactly BG_SETTLE_CYC cycles after bg_en and ref_en rise. core_en is never high unless bg_en and ref_en are high.
- R5: In staged mode ready rises exactly CORE_SETTLE_CYC cycles after core_en rises.
- R6: A power-up request accepted in simultaneous mode (staged_mode = 0) raises all three enables in the same cycle, and ready rises exactly BG_SETTLE_CYC cycles later.
- R7: Conversion requests made while a bring-up delay is running are held as one pending request. That request appears as a single one-cycle conv_start pulse in the first ready cycle, however many requests arrived. Requests made while idle are ignored.
- R8: While ready, each cycle with conv_req high gives a conv_start pulse on the next cycle. conv_start is never high without ready.
- R9: A power-down request in any state lowers bg_en, ref_en, core_en, ready and conv_start on the next cycle, drops a pending request, and leaves clk_en equal to keep_clk. It wins over a power-up request in the same cycle.
- R10: A power-up request made while a bring-up is running, or while ready, has no effect. After a power-down, a new request repeats the full delays.
- R11: staged_mode is sampled only when a power-up request is accepted. Changing it during a bring-up does not alter the timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| keep_clk | input | 1 | Keep converter clock running while idle |
| pwr_up_req | input | 1 | Start bring-up sequence |
| pwr_dn_req | input | 1 | Power everything down |
| staged_mode | input | 1 | 1 = staged bring-up, 0 = simultaneous |
| conv_req | input | 1 | Conversion request from the system |
| clk_en | output | 1 | Converter clock enable |
| bg_en | output | 1 | Band-gap enable |
| ref_en | output | 1 | Reference enable |
| core_en | output | 1 | Converter core enable |
| ready | output | 1 | All settling delays have elapsed |
| conv_start | output | 1 | One-cycle start pulse to the conversion engine |
| pwr_state | output | 2 | Current operating mode (see R2) |

## Verification
The bench builds the block with BG_SETTLE_CYC = 40 and CORE_SETTLE_CYC = 6 in place of delays worth many thousands of cycles. This lets a run go through every bring-up path, restarts and aborts in a few hundred cycles. The core delay is kept at three or more cycles so that the bench can place a second pending conversion request inside the core wait. The two delays also differ, so mixing them up between the staged and simultaneous paths shifts the ready edge by a visible number of cycles.

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
  parameter int BG_SETTLE_CYC   = 500000,
  parameter int CORE_SETTLE_CYC = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       keep_clk,
  input  logic       pwr_up_req,
  input  logic       pwr_dn_req,
  input  logic       staged_mode,
  input  logic       conv_req,
  output logic       clk_en,
  output logic       bg_en,
  output logic       ref_en,
  output logic       core_en,
  output logic       ready,
  output logic       conv_start,
  output logic [1:0] pwr_state
);

  localparam int MAX_CYC = (BG_SETTLE_CYC > CORE_SETTLE_CYC) ? BG_SETTLE_CYC : CORE_SETTLE_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] BG_LOAD   = CW'(BG_SETTLE_CYC - 1);
  localparam logic [CW-1:0] CORE_LOAD = CW'(CORE_SETTLE_CYC - 1);

  typedef enum logic [2:0] {
    S_IDLE,
    S_BG_WAIT,
    S_CORE_WAIT,
    S_SIM_WAIT,
    S_READY
  } seq_t;

  seq_t          st;
  logic [CW-1:0] cnt;
  logic          pend;
  logic          cnt_done;

  assign cnt_done = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      cnt        <= '0;
      clk_en     <= 1'b0;
      bg_en      <= 1'b0;
      ref_en     <= 1'b0;
      core_en    <= 1'b0;
      ready      <= 1'b0;
      pend       <= 1'b0;
      conv_start <= 1'b0;
    end else if (pwr_dn_req) begin
      st         <= S_IDLE;
      cnt        <= '0;
      clk_en     <= keep_clk;
      bg_en      <= 1'b0;
      ref_en     <= 1'b0;
      core_en    <= 1'b0;
      ready      <= 1'b0;
      pend       <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      case (st)
        S_IDLE: begin
          clk_en <= keep_clk;
          if (pwr_up_req) begin
            clk_en <= 1'b1;
            bg_en  <= 1'b1;
            ref_en <= 1'b1;
            cnt    <= BG_LOAD;
            if (staged_mode) begin
              st <= S_BG_WAIT;
            end else begin
              core_en <= 1'b1;
              st      <= S_SIM_WAIT;
            end
          end
        end
        S_BG_WAIT: begin
          pend <= pend | conv_req;
          if (cnt_done) begin
            core_en <= 1'b1;
            cnt     <= CORE_LOAD;
            st      <= S_CORE_WAIT;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_CORE_WAIT, S_SIM_WAIT: begin
          if (cnt_done) begin
            ready      <= 1'b1;
            conv_start <= pend | conv_req;
            pend       <= 1'b0;
            st         <= S_READY;
          end else begin
            pend <= pend | conv_req;
            cnt  <= cnt - 1'b1;
          end
        end
        S_READY: begin
          conv_start <= conv_req;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign pwr_state = !clk_en  ? 2'd0 :
                     !bg_en   ? 2'd1 :
                     !core_en ? 2'd2 : 2'd3;

  // R4
  core_needs_bias_chk: assert property (@(posedge clk) disable iff (rst)
    core_en |-> (bg_en && ref_en));

  // R8
  start_only_ready_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> ready);

  // R9
  power_down_clears_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_dn_req |=> (!bg_en && !ref_en && !core_en && !ready && !conv_start));

  // R5
  ready_after_core_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (core_en && $past(core_en)));

  // R10
  ready_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && !pwr_dn_req) |=> ready);

endmodule

// File: tb/adc_pwr_seq_tb.sv
module adc_pwr_seq_tb;
  localparam int BG   = 40;
  localparam int CORE = 6;

  logic clk = 1'b0;
  logic rst, keep_clk, pwr_up_req, pwr_dn_req, staged_mode, conv_req;
  logic clk_en, bg_en, ref_en, core_en, ready, conv_start;
  logic [1:0] pwr_state;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t0;
  int exp_q[$];
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_pwr_seq #(.BG_SETTLE_CYC(BG), .CORE_SETTLE_CYC(CORE)) u_dut (
    .clk(clk), .rst(rst), .keep_clk(keep_clk), .pwr_up_req(pwr_up_req),
    .pwr_dn_req(pwr_dn_req), .staged_mode(staged_mode), .conv_req(conv_req),
    .clk_en(clk_en), .bg_en(bg_en), .ref_en(ref_en), .core_en(core_en),
    .ready(ready), .conv_start(conv_start), .pwr_state(pwr_state)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: every conv_start pulse must match the next expected cycle
  always @(negedge clk) begin
    if (!rst && conv_start) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7/R8 conv_start: actual=pulse@%0d expected=none", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          errors++;
          $display("FAIL R7/R8 conv_start: actual=%0d expected=%0d", cyc, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; keep_clk = 0; pwr_up_req = 0; pwr_dn_req = 0; staged_mode = 1; conv_req = 0;
    step(3);
    // R1 reset state
    chk("R1 clk_en", clk_en, 0);
    chk("R1 enables", {bg_en, ref_en, core_en}, 0);
    chk("R1 ready/start", {ready, conv_start}, 0);
    chk("R1 pwr_state", pwr_state, 0);
    rst = 0;

    // R2 idle clock and low-power encoding
    keep_clk = 1; step(1);
    chk("R2 clk_en kept", clk_en, 1);
    chk("R2 state low-power", pwr_state, 1);
    keep_clk = 0; step(1);
    chk("R2 state off", pwr_state, 0);

    // R7 request while idle is ignored
    conv_req = 1; step(1); conv_req = 0; step(1);

    // R3 R4 R5 R11 staged bring-up
    staged_mode = 1; pwr_up_req = 1; step(1); pwr_up_req = 0;
    t0 = cyc;
    chk("R3 bias on", {clk_en, bg_en, ref_en}, 3'b111);
    chk("R3 core off", core_en, 0);
    chk("R3 state standby", pwr_state, 2);
    conv_req = 1; staged_mode = 0;
    step(1); conv_req = 0;
    step(BG - 2);
    chk("R4 core before delay", core_en, 0);
    step(1);
    chk("R4 core at delay", core_en, 1);
    chk("R11 mode change ignored", core_en, 1);
    chk("R2 state operational", pwr_state, 3);
    conv_req = 1;
    exp_q.push_back(t0 + BG + CORE);
    step(1); conv_req = 0;
    step(CORE - 2);
    chk("R5 ready before delay", ready, 0);
    step(1);
    chk("R5 ready at delay", ready, 1);

    // R10 power-up while ready
    pwr_up_req = 1; step(1); pwr_up_req = 0;
    chk("R10 ready kept", ready, 1);
    chk("R10 enables kept", {bg_en, ref_en, core_en}, 3'b111);
    step(2);

    // R8 back-to-back requests when ready
    conv_req = 1; exp_q.push_back(cyc + 1); step(1);
    exp_q.push_back(cyc + 1); step(1);
    conv_req = 0; step(2);

    // R9 power-down with clock kept
    keep_clk = 1; pwr_dn_req = 1; step(1); pwr_dn_req = 0;
    chk("R9 enables off", {bg_en, ref_en, core_en, ready}, 0);
    chk("R9 clk_en = keep_clk", clk_en, 1);
    chk("R9 state low-power", pwr_state, 1);
    keep_clk = 0;

    // R9 pending request dropped, R10 full restart
    staged_mode = 1; pwr_up_req = 1; step(1); pwr_up_req = 0;
    conv_req = 1; step(1); conv_req = 0; step(3);
    pwr_dn_req = 1; step(1); pwr_dn_req = 0;
    chk("R9 abort ready", ready, 0);
    chk("R9 abort state", pwr_state, 0);
    pwr_up_req = 1; step(1); pwr_up_req = 0;
    step(BG + CORE - 1);
    chk("R10 restart not early", ready, 0);
    step(1);
    chk("R10 restart full delay", ready, 1);
    step(3);
    chk("R7 dropped pending", exp_q.size(), 0);

    // R6 simultaneous bring-up
    pwr_dn_req = 1; step(1); pwr_dn_req = 0;
    staged_mode = 0; pwr_up_req = 1; step(1); pwr_up_req = 0;
    t0 = cyc;
    chk("R6 all enables", {bg_en, ref_en, core_en}, 3'b111);
    chk("R6 not ready", ready, 0);
    conv_req = 1; exp_q.push_back(t0 + BG);
    step(1); conv_req = 0;
    step(BG - 2);
    chk("R6 ready before delay", ready, 0);
    step(1);
    chk("R6 ready at delay", ready, 1);
    step(2);

    // R9 down wins over up
    pwr_dn_req = 1; step(1); pwr_dn_req = 0;
    pwr_up_req = 1; pwr_dn_req = 1; step(1); pwr_up_req = 0; pwr_dn_req = 0;
    chk("R9 down beats up", {bg_en, ref_en, core_en}, 0);
    chk("R9 state off", pwr_state, 0);
    step(2);
    chk("R7/R8 all pulses seen", exp_q.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule